// File: doc/BRIEF.md
# Split Serial Access Register

This block is the serial side of a dual-ported video-style memory. It holds one row's worth of words, 512 by 8 bits by default, next to a random-access array. A transfer request moves data between the two. A read transfer copies a row from the array into the register. A write transfer copies the register out toward the array. After a transfer, a serial pointer steps through the register, one word per enabled clock edge. Each step either drives the word out or overwrites it with the serial input.

The register is also treated as two halves, lower and upper. A split transfer touches only the half the pointer is not in. Serial traffic on the active half keeps running in the same cycles. When the pointer leaves the last word of a half, it jumps to a start offset stored by the most recent split transfer into the other half. If no such offset is pending, it jumps to the first word of that half. A flag output tells which half is active. The storage is static, so it needs no refresh.

Top module: `split_sam`

## Requirements
- R1: After synchronous reset, `sdo` is 0, `upper_active` is 0, `row_out_vld` is 0, and the port is in output mode.
- R2: A full transfer (`xfer_req`=1, `xfer_split`=0) sets the pointer to `xfer_tap` on the next edge. With `xfer_wr`=0, it also loads all words, where word i is taken from `row_in[8*i +: 8]`. Any `sclk_en` in the same cycle has no effect.
- R3: On an edge with `sclk_en`=1 in output mode, `sdo` takes the word at the pointer, valid after that edge, and the pointer advances by one.
- R4: With `sclk_en`=0 and no transfer, the pointer, `sdo` and the stored words all keep their values.
- R5: Shifting past word 255 or 511 sends the pointer to the other half, at the offset stored by the last split transfer that targeted that half.
- R6: If no offset is pending for the destination half, the pointer goes to that half's first word (256 or 0). An offset is used by one crossing only, and a full transfer discards pending offsets.
- R7: `upper_active` is 1 exactly while the pointer is in words 256 to 511.
- R8: A split read transfer (`xfer_split`=1, `xfer_wr`=0) loads only the half opposite the pointer, from the matching slice of `row_in`. Shifting in the same cycle and afterwards continues on the active half.
- R9: Any write transfer switches the port to input mode from the next edge on. Each enabled edge then stores `sdi` at the pointer and advances it, while `sdo` holds.
- R10: A full write transfer places all words on `row_out`, word i at `row_out[8*i +: 8]`. `row_out_vld` pulses high for one cycle, the cycle after the request.
- R11: A split write transfer updates only the slice of `row_out` for the half opposite the pointer. The other slice keeps its previous contents, and `row_out_vld` pulses as in R10.
- R12: Any read transfer returns the port to output mode from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial and transfer clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_req | input | 1 | Transfer request, one cycle |
| xfer_wr | input | 1 | 1: register to row (write), 0: row to register (read) |
| xfer_split | input | 1 | 1: move only the inactive half |
| xfer_tap | input | 9 | Start word (full transfer) or offset in half (low 8 bits, split transfer) |
| row_in | input | 4096 | Row data from the array, word i at bits 8*i+7..8*i |
| row_out | output | 4096 | Row data toward the array, same layout |
| row_out_vld | output | 1 | One-cycle pulse after a write transfer |
| sclk_en | input | 1 | Serial shift enable |
| sdi | input | 8 | Serial data in (input mode) |
| sdo | output | 8 | Serial data out, registered |
| upper_active | output | 1 | High while the pointer is in the upper half |

## Verification
Every result in this block is due exactly one edge after its stimulus. That covers the pointer jump after a transfer, the word on `sdo` after a shift, the half flag after a crossing, and the `row_out` update with its `row_out_vld` pulse. A change of direction applies only from the edge after the transfer. The bench drives inputs on falling edges and updates a behavioural model on each rising edge. It compares `sdo`, `upper_active`, `row_out_vld` and, on valid cycles, `row_out` on the following falling edge, so every comparison lands on the cycle the result is due. Long shift runs cross both half boundaries, with an offset pending and without one.

// File: rtl/sam_pkg.sv
package sam_pkg;

    localparam int SAM_DEPTH = 512;
    localparam int SAM_WIDTH = 8;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } sdir_e;

    typedef enum logic [1:0] {
        XF_NONE  = 2'd0,
        XF_FULL  = 2'd1,
        XF_SPLIT = 2'd2
    } xkind_e;

    function automatic xkind_e decode_kind(input logic req, input logic split);
        if (!req)  return XF_NONE;
        if (split) return XF_SPLIT;
        return XF_FULL;
    endfunction

    function automatic sdir_e dir_after(input logic wr);
        return wr ? DIR_IN : DIR_OUT;
    endfunction

endpackage

// File: rtl/sam_ptr_ctrl.sv
module sam_ptr_ctrl
    import sam_pkg::*;
#(
    parameter int DEPTH = SAM_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  xkind_e                     kind,
    input  logic                       xfer_wr,
    input  logic [$clog2(DEPTH)-1:0]   xfer_tap,
    input  logic                       shift_act,
    output logic [$clog2(DEPTH)-1:0]   ptr,
    output sdir_e                      dir
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int OFS_W = PTR_W - 1;

    logic [OFS_W-1:0] tap_q [2];
    logic [1:0]       tap_v;
    logic             inact;
    logic             at_end;
    logic [OFS_W-1:0] land_ofs;

    assign inact    = ~ptr[PTR_W-1];
    assign at_end   = &ptr[OFS_W-1:0];
    assign land_ofs = tap_v[inact] ? tap_q[inact] : {OFS_W{1'b0}};

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            dir      <= DIR_OUT;
            tap_v    <= '0;
            tap_q[0] <= '0;
            tap_q[1] <= '0;
        end else if (kind == XF_FULL) begin
            ptr   <= xfer_tap;
            dir   <= dir_after(xfer_wr);
            tap_v <= '0;
        end else begin
            if (shift_act) begin
                if (at_end) begin
                    ptr          <= {inact, land_ofs};
                    tap_v[inact] <= 1'b0;
                end else begin
                    ptr <= ptr + 1'b1;
                end
            end
            if (kind == XF_SPLIT) begin
                tap_q[inact] <= xfer_tap[OFS_W-1:0];
                tap_v[inact] <= 1'b1;
                dir          <= dir_after(xfer_wr);
            end
        end
    end

    // R4: pointer is frozen without shift or transfer
    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!shift_act && kind == XF_NONE) |=> $stable(ptr));

    // R3: ordinary step inside a half
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (shift_act && kind != XF_FULL && !at_end) |=> (ptr == $past(ptr) + 1'b1));

    // R5: leaving the end of a half always changes half
    p_cross_half_r5: assert property (@(posedge clk) disable iff (rst)
        (shift_act && kind != XF_FULL && at_end) |=> (ptr[PTR_W-1] != $past(ptr[PTR_W-1])));

    // R2: full transfer places the pointer on the given start word
    p_full_tap_r2: assert property (@(posedge clk) disable iff (rst)
        (kind == XF_FULL) |=> (ptr == $past(xfer_tap)));

    // R9 / R12: direction follows the latest transfer
    p_dir_in_r9: assert property (@(posedge clk) disable iff (rst)
        (kind != XF_NONE && xfer_wr) |=> (dir == DIR_IN));
    p_dir_out_r12: assert property (@(posedge clk) disable iff (rst)
        (kind != XF_NONE && !xfer_wr) |=> (dir == DIR_OUT));

endmodule

// File: rtl/sam_store.sv
module sam_store
    import sam_pkg::*;
#(
    parameter int DEPTH = SAM_DEPTH,
    parameter int WIDTH = SAM_WIDTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  xkind_e                     kind,
    input  logic                       xfer_wr,
    input  logic                       shift_act,
    input  logic [$clog2(DEPTH)-1:0]   ptr,
    input  sdir_e                      dir,
    input  logic [WIDTH-1:0]           sdi,
    input  logic [DEPTH*WIDTH-1:0]     row_in,
    output logic [DEPTH*WIDTH-1:0]     row_out,
    output logic                       row_out_vld,
    output logic [WIDTH-1:0]           sdo
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int HALF  = DEPTH / 2;

    logic [WIDTH-1:0] mem [DEPTH];
    logic             inact;
    int               half_base;

    assign inact     = ~ptr[PTR_W-1];
    assign half_base = inact ? HALF : 0;

    // static storage: no reset
    always_ff @(posedge clk) begin
        if (kind == XF_FULL) begin
            if (!xfer_wr) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[i] <= row_in[i*WIDTH +: WIDTH];
                end
            end
        end else begin
            if (kind == XF_SPLIT && !xfer_wr) begin
                for (int i = 0; i < HALF; i++) begin
                    mem[PTR_W'(half_base + i)] <= row_in[(half_base + i)*WIDTH +: WIDTH];
                end
            end
            if (shift_act && dir == DIR_IN) begin
                mem[ptr] <= sdi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo         <= '0;
            row_out     <= '0;
            row_out_vld <= 1'b0;
        end else begin
            row_out_vld <= (kind != XF_NONE) && xfer_wr;
            if (kind == XF_FULL && xfer_wr) begin
                for (int i = 0; i < DEPTH; i++) begin
                    row_out[i*WIDTH +: WIDTH] <= mem[i];
                end
            end
            if (kind == XF_SPLIT && xfer_wr) begin
                for (int i = 0; i < HALF; i++) begin
                    row_out[(half_base + i)*WIDTH +: WIDTH] <= mem[PTR_W'(half_base + i)];
                end
            end
            if (shift_act && dir == DIR_OUT) begin
                sdo <= mem[ptr];
            end
        end
    end

    // R4 / R9: serial output only moves on an output-mode shift
    p_sdo_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(shift_act && dir == DIR_OUT) |=> $stable(sdo));

    // R10: every write transfer yields a valid pulse next cycle
    p_vld_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (kind != XF_NONE && xfer_wr) |=> row_out_vld);

    // R11: row_out changes only on a write-transfer response
    p_row_out_stable_r11: assert property (@(posedge clk) disable iff (rst)
        !(kind != XF_NONE && xfer_wr) |=> $stable(row_out));

endmodule

// File: rtl/split_sam.sv
module split_sam
    import sam_pkg::*;
#(
    parameter int DEPTH = SAM_DEPTH,
    parameter int WIDTH = SAM_WIDTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       xfer_req,
    input  logic                       xfer_wr,
    input  logic                       xfer_split,
    input  logic [$clog2(DEPTH)-1:0]   xfer_tap,
    input  logic [DEPTH*WIDTH-1:0]     row_in,
    output logic [DEPTH*WIDTH-1:0]     row_out,
    output logic                       row_out_vld,
    input  logic                       sclk_en,
    input  logic [WIDTH-1:0]           sdi,
    output logic [WIDTH-1:0]           sdo,
    output logic                       upper_active
);
    localparam int PTR_W = $clog2(DEPTH);

    xkind_e           kind;
    logic             shift_act;
    logic [PTR_W-1:0] ptr;
    sdir_e            dir;

    assign kind         = decode_kind(xfer_req, xfer_split);
    assign shift_act    = sclk_en && (kind != XF_FULL);
    assign upper_active = ptr[PTR_W-1];

    sam_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .xfer_wr   (xfer_wr),
        .xfer_tap  (xfer_tap),
        .shift_act (shift_act),
        .ptr       (ptr),
        .dir       (dir)
    );

    sam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk         (clk),
        .rst         (rst),
        .kind        (kind),
        .xfer_wr     (xfer_wr),
        .shift_act   (shift_act),
        .ptr         (ptr),
        .dir         (dir),
        .sdi         (sdi),
        .row_in      (row_in),
        .row_out     (row_out),
        .row_out_vld (row_out_vld),
        .sdo         (sdo)
    );

    // R7: flag follows a half change caused by a full transfer
    p_flag_full_r7: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_split) |=> (upper_active == $past(xfer_tap[PTR_W-1])));

    // R1: reset leaves the outputs cleared
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (sdo == '0 && !upper_active && !row_out_vld));

endmodule

// File: tb/split_sam_bench.sv
module split_sam_bench;
    localparam int N = 512;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           xfer_req = 1'b0, xfer_wr = 1'b0, xfer_split = 1'b0;
    logic [8:0]     xfer_tap = '0;
    logic [N*W-1:0] row_in = '0;
    logic [N*W-1:0] row_out;
    logic           row_out_vld;
    logic           sclk_en = 1'b0;
    logic [W-1:0]   sdi = '0;
    logic [W-1:0]   sdo;
    logic           upper_active;

    int    total = 0;
    int    bad   = 0;
    string phase = "R1";
    bit    done  = 1'b0;

    always #10 clk = ~clk;

    split_sam u_split_sam (
        .clk(clk), .rst(rst), .xfer_req(xfer_req), .xfer_wr(xfer_wr),
        .xfer_split(xfer_split), .xfer_tap(xfer_tap), .row_in(row_in),
        .row_out(row_out), .row_out_vld(row_out_vld), .sclk_en(sclk_en),
        .sdi(sdi), .sdo(sdo), .upper_active(upper_active)
    );

    // behavioural reference
    logic [7:0] m_mem [N];
    logic [7:0] m_out [N];
    int         m_ptr;
    bit         m_outmode;
    int         m_tap [2];
    bit         m_tapv [2];
    logic [7:0] m_sdo;
    bit         m_vld;

    always @(posedge clk) begin
        if (rst) begin
            m_ptr = 0; m_outmode = 1; m_sdo = 0; m_vld = 0;
            m_tapv[0] = 0; m_tapv[1] = 0;
            for (int i = 0; i < N; i++) m_out[i] = 0;
        end else begin
            bit full;
            bit sact;
            int h;
            full = xfer_req && !xfer_split;
            sact = sclk_en && !full;
            h    = (m_ptr >= N/2) ? 0 : 1;
            m_vld = xfer_req && xfer_wr;
            if (full) begin
                for (int i = 0; i < N; i++) begin
                    if (xfer_wr) m_out[i] = m_mem[i];
                    else         m_mem[i] = row_in[i*W +: W];
                end
                m_ptr = int'(xfer_tap);
                m_outmode = !xfer_wr;
                m_tapv[0] = 0; m_tapv[1] = 0;
            end else begin
                bit old_mode;
                old_mode = m_outmode;
                if (xfer_req) begin
                    for (int i = h*N/2; i < (h+1)*N/2; i++) begin
                        if (xfer_wr) m_out[i] = m_mem[i];
                        else         m_mem[i] = row_in[i*W +: W];
                    end
                end
                if (sact) begin
                    if (old_mode) m_sdo = m_mem[m_ptr];
                    else          m_mem[m_ptr] = sdi;
                    if (m_ptr % (N/2) == N/2 - 1) begin
                        int d;
                        d = (m_ptr >= N/2) ? 0 : 1;
                        m_ptr = d*N/2 + (m_tapv[d] ? m_tap[d] : 0);
                        m_tapv[d] = 0;
                    end else begin
                        m_ptr = m_ptr + 1;
                    end
                end
                if (xfer_req) begin
                    m_tap[h]  = int'(xfer_tap[7:0]);
                    m_tapv[h] = 1;
                    m_outmode = !xfer_wr;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(phase, "sdo", longint'(sdo), longint'(m_sdo));
            chk(phase, "upper_active", longint'(upper_active), longint'(m_ptr >= N/2));
            chk(phase, "row_out_vld", longint'(row_out_vld), longint'(m_vld));
            if (m_vld) begin
                int mism;
                mism = 0;
                for (int i = 0; i < N; i++)
                    if (row_out[i*W +: W] !== m_out[i]) mism++;
                chk(phase, "row_out mismatching words", longint'(mism), 0);
            end
        end
    end

    task automatic fill(input logic [7:0] seed);
        for (int i = 0; i < N; i++) row_in[i*W +: W] = 8'(i*7) ^ seed;
    endtask

    task automatic step(input bit req, input bit wr, input bit split,
                        input int tap, input bit en, input logic [7:0] d);
        xfer_req = req; xfer_wr = wr; xfer_split = split;
        xfer_tap = 9'(tap); sclk_en = en; sdi = d;
        @(negedge clk);
        xfer_req = 0; sclk_en = 0;
    endtask

    task automatic shifts(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 8'(i*3 + 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        phase = "R1";
        repeat (2) @(negedge clk);
        chk("R1", "sdo after reset", longint'(sdo), 0);
        chk("R1", "upper_active after reset", longint'(upper_active), 0);

        phase = "R2";
        fill(8'h11);
        step(1, 0, 0, 250, 1, 8'h00);
        phase = "R3";
        shifts(5);
        chk("R3", "word 254 on sdo", longint'(sdo), longint'(8'(254*7) ^ 8'h11));
        phase = "R6";
        shifts(3);
        phase = "R7";
        shifts(2);
        chk("R7", "upper half active", longint'(upper_active), 1);
        phase = "R4";
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 8'(i + 9));

        phase = "R8";
        fill(8'h5A);
        step(1, 0, 1, 20, 1, 8'h00);
        shifts(20);
        phase = "R5";
        shifts(260);
        phase = "R6";
        shifts(520);

        phase = "R11";
        step(1, 1, 1, 5, 1, 8'hA5);
        phase = "R9";
        shifts(12);
        phase = "R4";
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 8'hEE);
        phase = "R10";
        step(1, 1, 0, 0, 1, 8'h77);
        @(negedge clk);

        phase = "R12";
        fill(8'h33);
        step(1, 0, 0, 300, 0, 8'h00);
        shifts(6);
        chk("R12", "word 305 on sdo", longint'(sdo), longint'(8'(305*7) ^ 8'h33));
        phase = "R2";
        step(1, 0, 0, 100, 1, 8'h00);
        chk("R2", "shift with full transfer ignored", longint'(sdo), longint'(8'(305*7) ^ 8'h33));
        shifts(2);
        chk("R2", "word 101 on sdo", longint'(sdo), longint'(8'(101*7) ^ 8'h33));

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule